// File: doc/BRIEF.md
# Serial codec control port

This block is the slave end of the serial control link of a telephony codec. A host frames each transfer with an active-low select and toggles a slow control clock. The block collects one or two bytes per instruction. The first byte carries a power flag and a register code, and says whether the transfer is a write or a read and whether a data byte follows. On a write, the data byte is stored in one of ten 8-bit settings registers. On a read, the stored value is shifted back on the serial output, which is only enabled while the select is low.

Every instruction updates the block's power state. When the codec leaves power-down, the PCM transmit output stays disabled until the second transmit frame-sync pulse has been seen. The control clock, the select, the serial data and the frame sync arrive asynchronously. They are brought into the fast system clock domain through a two-flop synchronizer, and the control clock edges are detected after that synchronizer.

Top module: `codec_ctl_port`

## Requirements
- R1: A byte is framed by exactly 8 falling edges of `ctl_clk` while `ctl_csn` is low. `ctl_din` is sampled on each falling edge, and the most significant bit is sent first.
- R2: The first byte of an instruction is decoded as follows. Bit 7 is the power flag (1 = power down, 0 = power up). Bits 6..3 are the register code. Bit 2 selects a read when it is 1. Bit 1 announces a data byte when it is 1. Bit 0 has no effect.
- R3: On a write, the data byte is stored in the addressed register when its 8th falling edge arrives. A later read of that code returns the stored value on `ctl_dout`, MSB first. `ctl_dout` changes only after a rising edge of `ctl_clk`.
- R4: The data byte may follow the first byte in the same low-select window. It may also come in a later window, because the pending instruction survives a high period of the select.
- R5: Several complete instructions may follow each other inside one low-select window.
- R6: `ctl_dout_oe` is 0 while `ctl_csn` is high and 1 while it is low. It follows the select after the synchronizer delay.
- R7: A first byte with bit 1 = 0 is a power-only command. It leaves all registers unchanged, and the next byte is decoded as a new first byte.
- R8: If `ctl_csn` rises in the middle of a byte, the partial byte is discarded. The next byte then starts again from its first bit.
- R9: Writes to the unused codes 3 and 11..15 change no register, and reads of those codes return 0x00. The valid codes are 0, 1, 2 and 4..10.
- R10: `pwr_down` takes the power flag of every first byte, whether the instruction is one byte or two. It changes at no other time.
- R11: `pcm_oe` is 0 while the block is powered down. After a power-up it stays 0 until the second rising edge of `fsync_tx`, and then goes to 1.
- R12: After reset, `pwr_down` is 1, `pcm_oe` and `ctl_dout_oe` are 0, every register reads 0x00, and the next byte is taken as a first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_clk | input | 1 | Serial control clock from the host |
| ctl_csn | input | 1 | Active-low transfer select |
| ctl_din | input | 1 | Serial instruction and data input |
| ctl_dout | output | 1 | Serial read-back data |
| ctl_dout_oe | output | 1 | Output enable for `ctl_dout` (0 = high impedance) |
| fsync_tx | input | 1 | Transmit frame sync |
| pwr_down | output | 1 | Current power state (1 = powered down) |
| pcm_oe | output | 1 | Enable for the PCM transmit output |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 4-bit register code, two synchronizer stages and a two-pulse frame-sync wait. With a 4-bit code, all ten live registers can be written and read back, and so can the unused codes 3 and 11..15, so aliasing and dropped writes can both be seen on the serial output. The two-pulse wait makes the gap between power-up and PCM enable short enough to drive edge by edge. This lets the bench show that one frame-sync pulse is not enough and that the second one opens the output.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  typedef enum logic {PH_CMD, PH_DATA} phase_t;

  // Register codes that own storage: 0,1,2 and 4..10
  function automatic logic code_live(input logic [3:0] code);
    return (code != 4'd3) && (code <= 4'd10);
  endfunction
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/ctl_shift.sv
module ctl_shift #(
  parameter int DW = 8,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_s,
  input  logic          cs_act,
  input  logic          sdi_s,
  output logic          sclk_rise,
  output logic          byte_done,
  output logic [DW-1:0] byte_val,
  output logic [CW-1:0] bit_cnt
);
  logic          sclk_q;
  logic          sclk_fall;
  logic [DW-2:0] sr;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      bit_cnt <= '0;
      sr      <= '0;
    end else begin
      sclk_q <= sclk_s;
      if (!cs_act) begin
        bit_cnt <= '0;
      end else if (sclk_fall) begin
        sr      <= {sr[DW-3:0], sdi_s};
        bit_cnt <= (bit_cnt == CW'(DW-1)) ? '0 : bit_cnt + 1'b1;
      end
    end
  end

  assign byte_done = cs_act & sclk_fall & (bit_cnt == CW'(DW-1));
  assign byte_val  = {sr, sdi_s};
endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
  import ctl_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4,
  localparam int NR = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_act,
  input  logic          sclk_rise,
  input  logic          byte_done,
  input  logic [DW-1:0] byte_val,
  output logic          sdo,
  output logic          pwr_down
);
  phase_t        phase;
  logic          rd_pend;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] osr;
  logic [DW-1:0] mem [NR];

  logic          c_pwr, c_rd, c_two;
  logic [AW-1:0] c_addr;
  logic [DW-4-AW:0] unused_lsb;
  logic [DW-1:0] rd_data;
  logic          wr_en;

  assign c_pwr      = byte_val[DW-1];
  assign c_addr     = byte_val[DW-2 -: AW];
  assign c_rd       = byte_val[DW-2-AW];
  assign c_two      = byte_val[DW-3-AW];
  assign unused_lsb = byte_val[DW-4-AW:0];

  assign rd_data = code_live(4'(c_addr)) ? mem[c_addr] : '0;
  assign wr_en   = byte_done && (phase == PH_DATA) && !rd_pend && code_live(4'(addr_q));

  // settings storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NR; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[addr_q] <= byte_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_CMD;
      rd_pend  <= 1'b0;
      addr_q   <= '0;
      osr      <= '0;
      sdo      <= 1'b0;
      pwr_down <= 1'b1;
    end else begin
      if (byte_done) begin
        if (phase == PH_CMD) begin
          pwr_down <= c_pwr;
          if (c_two) begin
            phase   <= PH_DATA;
            addr_q  <= c_addr;
            rd_pend <= c_rd;
            osr     <= c_rd ? rd_data : '0;
          end
        end else begin
          phase   <= PH_CMD;
          rd_pend <= 1'b0;
        end
      end
      if (sclk_rise && cs_act && (phase == PH_DATA) && rd_pend) begin
        sdo <= osr[DW-1];
        osr <= {osr[DW-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/pcm_gate.sv
module pcm_gate #(
  parameter int FS_WAIT = 2,
  localparam int FCW = $clog2(FS_WAIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_down,
  input  logic fs_s,
  output logic pcm_oe
);
  logic           fs_q;
  logic [FCW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q   <= 1'b0;
      seen   <= '0;
      pcm_oe <= 1'b0;
    end else begin
      fs_q <= fs_s;
      if (pwr_down) begin
        seen   <= '0;
        pcm_oe <= 1'b0;
      end else if (!pcm_oe && fs_s && !fs_q) begin
        if (seen == FCW'(FS_WAIT - 1)) pcm_oe <= 1'b1;
        else                           seen   <= seen + 1'b1;
      end
    end
  end
endmodule

// File: rtl/codec_ctl_port.sv
module codec_ctl_port #(
  parameter int DW          = 8,
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FS_WAIT     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ctl_clk,
  input  logic ctl_csn,
  input  logic ctl_din,
  output logic ctl_dout,
  output logic ctl_dout_oe,
  input  logic fsync_tx,
  output logic pwr_down,
  output logic pcm_oe
);
  localparam int BCW = $clog2(DW);

  logic [3:0]     in_s;
  logic           cs_act;
  logic           sclk_rise;
  logic           byte_done;
  logic [DW-1:0]  byte_val;
  logic [BCW-1:0] bit_cnt;

  // {frame sync, select, data, clock}; select idles high
  ctl_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
    .clk(clk), .rst(rst),
    .d({fsync_tx, ctl_csn, ctl_din, ctl_clk}),
    .q(in_s)
  );

  assign cs_act = ~in_s[2];

  ctl_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst),
    .sclk_s(in_s[0]), .cs_act(cs_act), .sdi_s(in_s[1]),
    .sclk_rise(sclk_rise), .byte_done(byte_done),
    .byte_val(byte_val), .bit_cnt(bit_cnt)
  );

  ctl_decode #(.DW(DW), .AW(AW)) u_dec (
    .clk(clk), .rst(rst),
    .cs_act(cs_act), .sclk_rise(sclk_rise),
    .byte_done(byte_done), .byte_val(byte_val),
    .sdo(ctl_dout), .pwr_down(pwr_down)
  );

  pcm_gate #(.FS_WAIT(FS_WAIT)) u_gate (
    .clk(clk), .rst(rst),
    .pwr_down(pwr_down), .fs_s(in_s[3]),
    .pcm_oe(pcm_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) ctl_dout_oe <= 1'b0;
    else     ctl_dout_oe <= cs_act;
  end
endmodule

// File: rtl/codec_ctl_port_chk.sv
module codec_ctl_port_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_act,
  input logic          sclk_rise,
  input logic          byte_done,
  input logic [CW-1:0] bit_cnt,
  input logic          ctl_dout,
  input logic          ctl_dout_oe,
  input logic          pwr_down,
  input logic          pcm_oe
);
  p_dout_hiz_r6: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !ctl_dout_oe);

  p_dout_drive_r6: assert property (@(posedge clk) disable iff (rst)
    cs_act |=> ctl_dout_oe);

  p_partial_drop_r8: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (bit_cnt == '0));

  p_pwr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !byte_done |=> $stable(pwr_down));

  p_pcm_off_r11: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> !pcm_oe);

  p_dout_edge_r3: assert property (@(posedge clk) disable iff (rst)
    !sclk_rise |=> $stable(ctl_dout));
endmodule

bind codec_ctl_port codec_ctl_port_chk #(.CW($clog2(DW))) u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .sclk_rise(sclk_rise),
  .byte_done(byte_done), .bit_cnt(bit_cnt), .ctl_dout(ctl_dout),
  .ctl_dout_oe(ctl_dout_oe), .pwr_down(pwr_down), .pcm_oe(pcm_oe)
);

// File: tb/codec_ctl_port_bench.sv
module codec_ctl_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, csn = 1'b1, din = 1'b0, fs = 1'b0;
  logic dout, dout_oe, pwr_down, pcm_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic cur_p = 1'b1;

  // {code, data}
  localparam logic [11:0] VEC [10] = '{
    {4'd0, 8'hA5}, {4'd1, 8'h3C}, {4'd2, 8'h81}, {4'd4, 8'h7E}, {4'd5, 8'h12},
    {4'd6, 8'hF0}, {4'd7, 8'h0F}, {4'd8, 8'hC9}, {4'd9, 8'h56}, {4'd10, 8'hEB}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_ctl_port u_codec_ctl_port (
    .clk(clk), .rst(rst), .ctl_clk(sclk), .ctl_csn(csn), .ctl_din(din),
    .ctl_dout(dout), .ctl_dout_oe(dout_oe), .fsync_tx(fs),
    .pwr_down(pwr_down), .pcm_oe(pcm_oe)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] rb);
    rb = '0;
    for (int i = 7; i >= 0; i--) begin
      din = b[i]; sclk = 1'b1; wait_clk(HALF);
      rb[i] = dout; sclk = 1'b0; wait_clk(HALF);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      din = 1'b1; sclk = 1'b1; wait_clk(HALF);
      sclk = 1'b0; wait_clk(HALF);
    end
  endtask

  task automatic cs_low;  csn = 1'b0; wait_clk(4); endtask
  task automatic cs_high; wait_clk(4); csn = 1'b1; wait_clk(8); endtask

  function automatic logic [7:0] cmd(input logic p, input logic [3:0] a,
                                     input logic rd, input logic two);
    return {p, a, rd, two, 1'b0};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] rb;
    cs_low; xbyte(cmd(cur_p, a, 1'b0, 1'b1), rb); xbyte(d, rb); cs_high;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    logic [7:0] rb;
    cs_low; xbyte(cmd(cur_p, a, 1'b1, 1'b1), rb); xbyte(8'h00, v); cs_high;
  endtask

  task automatic fs_pulse;
    fs = 1'b1; wait_clk(4); fs = 1'b0; wait_clk(8);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [7:0] v, rb;
    wait_clk(5); rst = 1'b0; wait_clk(5);

    // R12 reset state
    chk("R12 pwr_down", {7'b0, pwr_down}, 8'h01);
    chk("R12 pcm_oe", {7'b0, pcm_oe}, 8'h00);
    chk("R6 oe with select high", {7'b0, dout_oe}, 8'h00);
    rd(4'd0, v); chk("R12 reg0 after reset", v, 8'h00);

    // R2 R3 table: write every live code, then read all back
    for (int i = 0; i < 10; i++) wr(VEC[i][11:8], VEC[i][7:0]);
    for (int i = 0; i < 10; i++) begin
      rd(VEC[i][11:8], v);
      chk($sformatf("R3 readback code %0d", VEC[i][11:8]), v, VEC[i][7:0]);
    end

    // R4 R5 R6: one 32-clock window holding two writes
    cs_low;
    chk("R6 oe with select low", {7'b0, dout_oe}, 8'h01);
    xbyte(cmd(cur_p, 4'd4, 1'b0, 1'b1), rb); xbyte(8'h3C, rb);
    xbyte(cmd(cur_p, 4'd5, 1'b0, 1'b1), rb); xbyte(8'hC3, rb);
    cs_high;
    rd(4'd4, v); chk("R5 first write in window", v, 8'h3C);
    rd(4'd5, v); chk("R5 second write in window", v, 8'hC3);

    // R4 split windows
    cs_low; xbyte(cmd(cur_p, 4'd6, 1'b0, 1'b1), rb); cs_high;
    chk("R6 oe between windows", {7'b0, dout_oe}, 8'h00);
    cs_low; xbyte(8'h77, rb); cs_high;
    rd(4'd6, v); chk("R4 split write", v, 8'h77);

    // R8 partial first byte dropped
    cs_low; pulses(3); cs_high;
    wr(4'd7, 8'h11);
    rd(4'd7, v); chk("R8 after partial first byte", v, 8'h11);
    // R8 partial data byte dropped, pending instruction kept (R4)
    cs_low; xbyte(cmd(cur_p, 4'd8, 1'b0, 1'b1), rb); cs_high;
    cs_low; pulses(4); cs_high;
    cs_low; xbyte(8'h99, rb); cs_high;
    rd(4'd8, v); chk("R8 partial data byte dropped", v, 8'h99);

    // R9 unused codes
    wr(4'd3, 8'hFF);
    rd(4'd3, v); chk("R9 read code 3", v, 8'h00);
    wr(4'd11, 8'hEE);
    rd(4'd11, v); chk("R9 read code 11", v, 8'h00);
    rd(4'd0, v); chk("R9 code 0 untouched", v, 8'hA5);
    rd(4'd2, v); chk("R9 code 2 untouched", v, 8'h81);

    // R2 bit 0 has no effect
    cs_low; xbyte(cmd(cur_p, 4'd9, 1'b0, 1'b1) | 8'h01, rb); xbyte(8'h5A, rb); cs_high;
    rd(4'd9, v); chk("R2 bit0 ignored", v, 8'h5A);

    // R7 power-only command, then a write in the same window
    chk("R11 off while powered down", {7'b0, pcm_oe}, 8'h00);
    cs_low; xbyte(cmd(1'b0, 4'd0, 1'b0, 1'b0), rb);
    cur_p = 1'b0;
    xbyte(cmd(cur_p, 4'd10, 1'b0, 1'b1), rb); xbyte(8'h42, rb); cs_high;
    chk("R7 power up", {7'b0, pwr_down}, 8'h00);
    rd(4'd10, v); chk("R7 next byte is a command", v, 8'h42);
    rd(4'd0, v); chk("R7 register untouched", v, 8'hA5);

    // R11 frame-sync gate
    chk("R11 closed after power-up", {7'b0, pcm_oe}, 8'h00);
    fs_pulse;
    chk("R11 closed after one sync", {7'b0, pcm_oe}, 8'h00);
    fs_pulse;
    chk("R11 open after second sync", {7'b0, pcm_oe}, 8'h01);

    // R10 power flag of one-byte and two-byte instructions
    cs_low; xbyte(cmd(1'b1, 4'd0, 1'b0, 1'b0), rb); cs_high;
    cur_p = 1'b1;
    chk("R10 power down one-byte", {7'b0, pwr_down}, 8'h01);
    chk("R11 closed when down", {7'b0, pcm_oe}, 8'h00);
    cur_p = 1'b0;
    wr(4'd1, 8'h66);
    chk("R10 power up two-byte", {7'b0, pwr_down}, 8'h00);
    chk("R11 closed after re-power", {7'b0, pcm_oe}, 8'h00);
    fs_pulse; fs_pulse;
    chk("R11 open again", {7'b0, pcm_oe}, 8'h01);
    rd(4'd1, v); chk("R3 write with power flag", v, 8'h66);
    chk("R1 serial framing intact", {7'b0, pwr_down}, 8'h00);

    summary();
  end
endmodule